// File: doc/BRIEF.md
# Programmable Half-Period Clock Stretcher

This block derives a slow, square output clock from a fast internal clock. Each output half-period lasts a programmable number of internal clock cycles: a counter advances on every enabled internal edge, and when it equals the stored control code, the output register flips and the counter returns to zero on that same edge. A 9-bit code therefore selects half-periods from 1 to 512 internal cycles. The full output period grows linearly with the code, which makes for a very wide output frequency range from one fast source.

The control code is captured only at a flip of the output, or while the block is idle. A code change in the middle of a half-period therefore never shortens or corrupts the half-period already running. The equality flag is brought out for the stage that follows. With a code of zero the flag is permanently high and the output flips on every internal edge, which is the shortest period.

Top module: `dtc_period_ext`

## Requirements
- R1: Synchronous active-high reset forces `clk_o` low, clears the counter and the stored code, so right after reset `eq_o` reads 1.
- R2: While `en_i` is high, every output half-period lasts exactly (stored code + 1) internal cycles, so the full period is 2*(code+1) cycles.
- R3: With a code of 0, `eq_o` stays high continuously and `clk_o` flips on every enabled internal edge.
- R4: A code of 511 gives the longest half-period of 512 internal cycles.
- R5: For a code above 0, `eq_o` is high in exactly one cycle per half-period: the cycle that ends with the flip of `clk_o`.
- R6: Changing `code_i` in the middle of a half-period leaves that half-period's length unchanged; the new code governs the next half-period.
- R7: A `code_i` value present at the edge where `clk_o` flips is the one captured for the following half-period.
- R8: While `en_i` is low, `clk_o` holds its level, the counter is held at zero and the code is captured on every edge; once `en_i` rises again, the first half-period lasts (code + 1) cycles from the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast internal clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Counting enable; low freezes the output |
| code_i | input | 9 | Added-cycle code, 0 to 511 |
| clk_o | output | 1 | Stretched output clock |
| eq_o | output | 1 | Counter equals stored code |

## Verification
Two functions can fall on the same edge: the flip of the output and the capture of a new code. The bench provokes this by changing `code_i` in the very cycle in which `eq_o` is high, just before the flipping edge. It then judges the result by the measured lengths of the following half-periods. A change placed a few cycles earlier, inside a running half-period, gives the contrast: it must leave the current length untouched and appear only in the next half-period.

// File: rtl/dtc_ctrl_pkg.sv
package dtc_ctrl_pkg;
  // Per-edge action decoded from enable and the match flag
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,  // enable low: hold level, clear count, capture code
    ACT_COUNT = 2'd1,  // enable high, no match: advance counter
    ACT_WRAP  = 2'd2   // enable high, match: flip output, clear count, capture code
  } dtc_act_e;
endpackage

// File: rtl/dtc_code_reg.sv
module dtc_code_reg
  import dtc_ctrl_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  dtc_act_e          act_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_q_o <= '0;
    end else if (act_i != ACT_COUNT) begin
      code_q_o <= code_i;
    end
  end

  // The stored code never moves inside a running half-period
  p_code_frozen_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i == ACT_COUNT) |=> $stable(code_q_o));
endmodule

// File: rtl/dtc_counter.sv
module dtc_counter
  import dtc_ctrl_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  dtc_act_e          act_i,
  input  logic [CODE_W-1:0] code_q_i,
  output logic              eq_o
);
  logic [CODE_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (act_i == ACT_COUNT) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  assign eq_o = (cnt_q == code_q_i);

  // Counter can never run past the stored code (R2 bound)
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= code_q_i);
  p_cnt_idle_clear_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i == ACT_IDLE) |=> (cnt_q == '0));
endmodule

// File: rtl/dtc_toggle.sv
module dtc_toggle
  import dtc_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  dtc_act_e act_i,
  output logic     clk_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_o <= 1'b0;
    end else if (act_i == ACT_WRAP) begin
      clk_o <= ~clk_o;
    end
  end

  p_flip_on_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i == ACT_WRAP) |=> (clk_o != $past(clk_o)));
  p_hold_otherwise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i != ACT_WRAP) |=> $stable(clk_o));
endmodule

// File: rtl/dtc_period_ext.sv
module dtc_period_ext
  import dtc_ctrl_pkg::*;
#(
  parameter int CODE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o,
  output logic              eq_o
);
  logic [CODE_W-1:0] code_q;
  logic              match;
  dtc_act_e          act;

  always_comb begin
    if (!en_i)      act = ACT_IDLE;
    else if (match) act = ACT_WRAP;
    else            act = ACT_COUNT;
  end

  dtc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk_i(clk_i), .rst_i(rst_i), .act_i(act), .code_i(code_i), .code_q_o(code_q)
  );

  dtc_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .act_i(act), .code_q_i(code_q), .eq_o(match)
  );

  dtc_toggle u_tog (
    .clk_i(clk_i), .rst_i(rst_i), .act_i(act), .clk_o(clk_o)
  );

  assign eq_o = match;

  // Zero code keeps the match permanently true
  p_zero_code_match_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_q == '0) |-> eq_o);
endmodule

// File: tb/dtc_period_ext_tb_top.sv
module dtc_period_ext_tb_top;
  localparam int CLK_PER = 10;
  localparam int CODE_W  = 9;
  localparam int NVEC    = 8;
  localparam int VEC_CODE [NVEC] = '{0, 1, 2, 5, 17, 100, 255, 511};
  localparam int VEC_HALF [NVEC] = '{1, 2, 3, 6, 18, 101, 256, 512};

  logic              clk = 1'b0;
  logic              rst;
  logic              en;
  logic [CODE_W-1:0] code;
  logic              clk_o;
  logic              eq_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PER/2) clk = ~clk;

  dtc_period_ext #(.CODE_W(CODE_W)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .code_i(code), .clk_o(clk_o), .eq_o(eq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Measure one half-period from the current negedge. Optionally drive a new
  // code after chg_at samples. Returns length, eq-high count, last eq value.
  task automatic measure(input int chg_at, input int new_code,
                         output int len, output int neq, output bit last_eq);
    bit prev;
    prev = clk_o;
    len = 0; neq = 0; last_eq = 1'b0;
    while (len < 2000) begin
      if (len == chg_at) code = new_code[CODE_W-1:0];
      last_eq = eq_o;
      if (eq_o) neq++;
      @(negedge clk);
      len++;
      if (clk_o != prev) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len, neq;
    bit leq, lvl;
    rst = 1'b1; en = 1'b0; code = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(clk_o == 1'b0, "R1 clk_o after reset", clk_o, 0);
    chk(eq_o == 1'b1, "R1 eq_o after reset", eq_o, 1);
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R2, R3, R4, R5
    for (int v = 0; v < NVEC; v++) begin
      en = 1'b0; code = VEC_CODE[v][CODE_W-1:0];
      repeat (2) @(negedge clk);
      en = 1'b1;
      for (int h = 0; h < 2; h++) begin
        measure(-1, 0, len, neq, leq);
        chk(len == VEC_HALF[v], (v == NVEC-1) ? "R4 half-period at 511" :
            (v == 0) ? "R3 half-period at 0" : "R2 half-period", len, VEC_HALF[v]);
        chk(neq == 1 && leq, "R5 single eq cycle before flip", neq, 1);
      end
    end

    // R3: zero code keeps eq high over many cycles
    en = 1'b0; code = '0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      lvl = clk_o;
      chk(eq_o == 1'b1, "R3 eq_o held high", eq_o, 1);
      @(negedge clk);
      chk(clk_o != lvl, "R3 flip every cycle", clk_o, !lvl);
    end

    // R6: mid-count change leaves current half intact
    en = 1'b0; code = 9'd10;
    repeat (2) @(negedge clk);
    en = 1'b1;
    measure(-1, 0, len, neq, leq);
    chk(len == 11, "R6 first half", len, 11);
    measure(3, 3, len, neq, leq);
    chk(len == 11, "R6 current half unchanged", len, 11);
    measure(-1, 0, len, neq, leq);
    chk(len == 4, "R6 new code next half", len, 4);

    // R7: change in the flip cycle is captured for the next half
    measure(3, 7, len, neq, leq);
    chk(len == 4, "R7 half with change at flip edge", len, 4);
    measure(-1, 0, len, neq, leq);
    chk(len == 8, "R7 following half uses new code", len, 8);

    // R8: enable low holds level, clears count, captures code
    en = 1'b0; code = 9'd6;
    repeat (2) @(negedge clk);
    en = 1'b1;
    measure(-1, 0, len, neq, leq);
    chk(len == 7, "R8 half before pause", len, 7);
    repeat (3) @(negedge clk);
    en = 1'b0;
    lvl = clk_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(clk_o == lvl, "R8 level held while idle", clk_o, lvl);
    end
    code = 9'd2;
    @(negedge clk);
    en = 1'b1;
    measure(-1, 0, len, neq, leq);
    chk(len == 3, "R8 restart with idle-captured code", len, 3);

    // R1: reset while output high
    if (clk_o == 1'b0) measure(-1, 0, len, neq, leq);
    rst = 1'b1;
    @(negedge clk);
    chk(clk_o == 1'b0, "R1 mid-run reset clears clk_o", clk_o, 0);
    chk(eq_o == 1'b1, "R1 mid-run reset eq_o", eq_o, 1);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule